// File: doc/BRIEF.md
# Serial Configuration Loader

This block is a master that loads a configuration bitstream into a programmable logic target through the target's one-bit serial configuration port. When `start_i` is pulsed, the loader pulls the target's active-low program pin low and waits for the target's active-low init pin to go low. It then releases program and waits for init to return high. Each timed wait has its own timeout, and a timeout ends the run as a failure.

After that handshake, the loader takes bytes from a valid/ready stream and sends each one most significant bit first. For every bit it takes the configuration clock low, changes the data line, and raises the clock, so the target samples on the rising edge. Before it takes each byte, the loader checks whether the target has signalled a CRC error, which is init low while the target's done pin is still low. After the byte marked last, it holds the data line high and keeps pulsing the clock until done reads high.

Readback is not available on this port. A readback request is answered with an immediate failure. Every change on a target pin is aligned to a pacing tick, so the pins never move faster than the target allows.

Top module: `cfg_serial_loader`

## Requirements
- R1: After `start_i`, `cfg_prog_n_o` is driven low and held low until the synchronised init input reads low. It is then driven high.
- R2: If init does not read low within `TIMEOUT_CYC` cycles of program going low, the run ends with `fail_o`=1 and `crc_err_o`=0, and `cfg_prog_n_o` is high again.
- R3: After program is released, the loader waits for init to read high. If that takes more than `TIMEOUT_CYC` cycles, the run ends with `fail_o`=1 and `crc_err_o`=0.
- R4: Each accepted byte appears on `cfg_din_o` most significant bit first, one bit per rising edge of `cfg_cclk_o`, and bytes go out in acceptance order.
- R5: `cfg_din_o` changes only while `cfg_cclk_o` is low, and the clock was already low in the cycle before the change.
- R6: Any two changes on the target pins (`cfg_prog_n_o`, `cfg_cclk_o`, `cfg_din_o`) are at least `DIV` system clock cycles apart.
- R7: `s_ready_o` is high only while the loader waits for a byte, with `cfg_cclk_o` high. Exactly 8 rising clock edges separate two accepted bytes of one run.
- R8: If init reads low while done reads low at the point where the next byte would be taken, no further byte is accepted, and the run ends with `crc_err_o`=1 and `fail_o`=1.
- R9: After the last byte (`s_last_i`=1 at acceptance), `cfg_din_o` is held at 1 and clock pulses continue until done reads high. The run then ends with `done_o`=1 and `fail_o`=0. If done stays low for `TIMEOUT_CYC` cycles, the run ends with `fail_o`=1.
- R10: A `readback_i` pulse while the loader is idle sets `fail_o`=1 on the next cycle, with `done_o`=0 and `crc_err_o`=0, and changes no target pin.
- R11: `done_o`, `fail_o` and `crc_err_o` hold their value until the next run starts, which clears them. `busy_o` is high from a start until the run ends. A `start_i` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a configuration run |
| readback_i | input | 1 | Readback request (always refused) |
| s_data_i | input | DATA_W | Stream byte |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Loader accepts a byte this cycle |
| busy_o | output | 1 | A run is pending or in progress |
| done_o | output | 1 | Last run completed with done high |
| fail_o | output | 1 | Last run or request failed |
| crc_err_o | output | 1 | Last run stopped on a CRC error indication |
| cfg_prog_n_o | output | 1 | Target program pin, active low |
| cfg_cclk_o | output | 1 | Configuration clock to the target |
| cfg_din_o | output | 1 | Serial configuration data to the target |
| cfg_init_n_i | input | 1 | Target init pin, active low |
| cfg_done_i | input | 1 | Target done pin |

## Verification
The assertions check the pin discipline on every cycle: data moves only under a low clock, pin changes are spaced by the pacing interval, and ready appears only with the clock high. They also check that the status outputs agree with one another, that a failure leaves program released, and that an idle readback fails on the next cycle. Other behaviours are visible only in the bench's scenarios, where a reactive target model drives init and done. These are the bit order of each byte through the scoreboard, the exact count of eight clock edges between accepted bytes, the length of each timeout, the CRC stop that refuses later bytes, and the ignored start pulse in the middle of a run.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [2:0] {
      LD_IDLE  = 3'd0,
      LD_PROG  = 3'd1,
      LD_REL   = 3'd2,
      LD_FETCH = 3'd3,
      LD_SHIFT = 3'd4,
      LD_FLUSH = 3'd5
   } ld_state_t;

   // sub-steps of one bit slot: clock low, data update, clock high
   typedef enum logic [1:0] {
      PH_CLK_LO = 2'd0,
      PH_DATA   = 2'd1,
      PH_CLK_HI = 2'd2
   } ld_phase_t;

endpackage

// File: rtl/cfg_pace_tick.sv
module cfg_pace_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("cfg_pace_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
   parameter int         W       = 2,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("cfg_pin_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[i] <= RST_VAL;
               else        stg_q[i] <= (i == 0) ? d_i : stg_q[(i == 0) ? 0 : i - 1];
            end
         end
         assign q_o = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   output logic expired_o
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("cfg_wait_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (clear_i)                   cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT))       cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q == CW'(LIMIT));

   a_r2_timer_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !clear_i) |=> expired_o);
endmodule

// File: rtl/cfg_byte_serializer.sv
module cfg_byte_serializer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] byte_i,
   input  logic         step_i,
   output logic         bit_o,
   output logic         last_bit_o
);
   localparam int CW = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("cfg_byte_serializer: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  sh_q;
   logic [CW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= byte_i;
         idx_q <= '0;
      end else if (step_i) begin
         sh_q  <= {sh_q[W-2:0], 1'b0};
         idx_q <= idx_q + 1'b1;
      end
   end

   assign bit_o      = sh_q[W-1];
   assign last_bit_o = (idx_q == CW'(W - 1));

   // R4: a fresh byte presents its top bit first
   a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (bit_o == $past(byte_i[W-1])) && (idx_q == '0));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_loader_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV         = 4,
   parameter int TIMEOUT_CYC = 2_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              readback_i,
   input  logic [DATA_W-1:0] s_data_i,
   input  logic              s_last_i,
   input  logic              s_valid_i,
   output logic              s_ready_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic              crc_err_o,
   output logic              cfg_prog_n_o,
   output logic              cfg_cclk_o,
   output logic              cfg_din_o,
   input  logic              cfg_init_n_i,
   input  logic              cfg_done_i
);
   localparam int GAP_W = $clog2(DIV + 1);

   generate
      if (DIV < 1)         begin : g_bad_div     $error("cfg_serial_loader: DIV < 1");         end
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout $error("cfg_serial_loader: TIMEOUT_CYC < 1"); end
   endgenerate

   // ---------------- helpers ----------------
   logic tick;
   logic init_n_s, done_s;
   logic expired, timer_clr;
   logic ser_load, ser_step, ser_bit, ser_last;

   cfg_pace_tick #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   cfg_pin_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({cfg_init_n_i, cfg_done_i}),
      .q_o({init_n_s, done_s}));

   cfg_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear_i(timer_clr), .expired_o(expired));

   cfg_byte_serializer #(.W(DATA_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .load_i(ser_load), .byte_i(s_data_i),
      .step_i(ser_step), .bit_o(ser_bit), .last_bit_o(ser_last));

   // ---------------- control state ----------------
   ld_state_t state_q, state_d;
   ld_phase_t phase_q, phase_d;
   logic cclk_q, cclk_d, din_q, din_d;
   logic last_q, last_d, pend_q, pend_d;
   logic done_q, done_d, fail_q, fail_d, crc_q, crc_d;
   logic crc_seen;

   assign crc_seen  = !init_n_s && !done_s;
   assign s_ready_o = (state_q == LD_FETCH) && !crc_seen;
   assign timer_clr = (state_d != state_q);

   always_comb begin
      state_d  = state_q;
      phase_d  = phase_q;
      cclk_d   = cclk_q;
      din_d    = din_q;
      last_d   = last_q;
      pend_d   = pend_q;
      done_d   = done_q;
      fail_d   = fail_q;
      crc_d    = crc_q;
      ser_load = 1'b0;
      ser_step = 1'b0;
      unique case (state_q)
         LD_IDLE: begin
            if (start_i) begin
               pend_d = 1'b1;
            end else if (readback_i && !pend_q) begin
               fail_d = 1'b1;
               done_d = 1'b0;
               crc_d  = 1'b0;
            end
            if (tick && pend_q) begin
               state_d = LD_PROG;
               pend_d  = 1'b0;
               done_d  = 1'b0;
               fail_d  = 1'b0;
               crc_d   = 1'b0;
            end
         end
         LD_PROG: if (tick) begin
            if (!init_n_s) begin
               state_d = LD_REL;
            end else if (expired) begin
               state_d = LD_IDLE;
               fail_d  = 1'b1;
            end
         end
         LD_REL: if (tick) begin
            if (init_n_s) begin
               state_d = LD_FETCH;
               cclk_d  = 1'b1;
            end else if (expired) begin
               state_d = LD_IDLE;
               fail_d  = 1'b1;
            end
         end
         LD_FETCH: begin
            if (s_valid_i && s_ready_o) begin
               ser_load = 1'b1;
               last_d   = s_last_i;
               state_d  = LD_SHIFT;
               phase_d  = PH_CLK_LO;
            end else if (tick && crc_seen) begin
               state_d = LD_IDLE;
               crc_d   = 1'b1;
               fail_d  = 1'b1;
            end
         end
         LD_SHIFT: if (tick) begin
            unique case (phase_q)
               PH_CLK_LO: begin cclk_d = 1'b0;    phase_d = PH_DATA;   end
               PH_DATA:   begin din_d  = ser_bit; phase_d = PH_CLK_HI; end
               default: begin
                  cclk_d   = 1'b1;
                  ser_step = 1'b1;
                  phase_d  = PH_CLK_LO;
                  if (ser_last) state_d = last_q ? LD_FLUSH : LD_FETCH;
               end
            endcase
         end
         LD_FLUSH: if (tick) begin
            if (phase_q == PH_CLK_LO && done_s) begin
               state_d = LD_IDLE;
               done_d  = 1'b1;
            end else if (expired) begin
               state_d = LD_IDLE;
               fail_d  = 1'b1;
               phase_d = PH_CLK_LO;
            end else begin
               unique case (phase_q)
                  PH_CLK_LO: begin cclk_d = 1'b0; phase_d = PH_DATA;   end
                  PH_DATA:   begin din_d  = 1'b1; phase_d = PH_CLK_HI; end
                  default:   begin cclk_d = 1'b1; phase_d = PH_CLK_LO; end
               endcase
            end
         end
         default: state_d = LD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         phase_q <= PH_CLK_LO;
         cclk_q  <= 1'b1;
         din_q   <= 1'b1;
         last_q  <= 1'b0;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         crc_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         cclk_q  <= cclk_d;
         din_q   <= din_d;
         last_q  <= last_d;
         pend_q  <= pend_d;
         done_q  <= done_d;
         fail_q  <= fail_d;
         crc_q   <= crc_d;
      end
   end

   assign cfg_prog_n_o = (state_q != LD_PROG);
   assign cfg_cclk_o   = cclk_q;
   assign cfg_din_o    = din_q;
   assign busy_o       = (state_q != LD_IDLE) || pend_q;
   assign done_o       = done_q;
   assign fail_o       = fail_q;
   assign crc_err_o    = crc_q;

   // ---------------- assertions ----------------
   logic [2:0]       pins_prev_q;
   logic [GAP_W-1:0] gap_q;
   logic             pin_chg;

   assign pin_chg = ({cfg_prog_n_o, cfg_cclk_o, cfg_din_o} != pins_prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_prev_q <= 3'b111;
         gap_q       <= GAP_W'(DIV);
      end else begin
         pins_prev_q <= {cfg_prog_n_o, cfg_cclk_o, cfg_din_o};
         if (pin_chg)                    gap_q <= GAP_W'(1);
         else if (gap_q != GAP_W'(DIV))  gap_q <= gap_q + 1'b1;
      end
   end

   a_r5_din_under_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_din_o != $past(cfg_din_o)) |-> (!cfg_cclk_o && !$past(cfg_cclk_o)));

   a_r6_pin_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      pin_chg |-> (gap_q >= GAP_W'(DIV)));

   a_r7_ready_with_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> (cfg_cclk_o && busy_o));

   a_r8_crc_stops_stream: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err_o |-> (fail_o && !s_ready_o && !done_o));

   a_r2_fail_releases_program: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> cfg_prog_n_o);

   a_r9_done_holds_din_high: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cfg_din_o && !fail_o));

   a_r10_readback_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (readback_i && !start_i && !busy_o) |=> (fail_o && !done_o && !crc_err_o && !busy_o));
endmodule

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
   localparam int DIV = 2;
   localparam int TMO = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, readback_i = 1'b0;
   logic [7:0] s_data_i = '0;
   logic s_last_i = 1'b0, s_valid_i = 1'b0;
   logic s_ready_o, busy_o, done_o, fail_o, crc_err_o;
   logic cfg_prog_n_o, cfg_cclk_o, cfg_din_o;
   logic init_n_m = 1'b1, done_m = 1'b0;

   always #2.5 clk = ~clk;

   cfg_serial_loader #(.DATA_W(8), .DIV(DIV), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .readback_i(readback_i),
      .s_data_i(s_data_i), .s_last_i(s_last_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .crc_err_o(crc_err_o),
      .cfg_prog_n_o(cfg_prog_n_o), .cfg_cclk_o(cfg_cclk_o), .cfg_din_o(cfg_din_o),
      .cfg_init_n_i(init_n_m), .cfg_done_i(done_m));

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000 && !finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- target model and monitor ----------------
   logic [7:0] exp_q [$];
   bit allow_init_low = 1, allow_init_high = 1, allow_done = 1, crc_mode = 0, crc_fired = 0;
   int done_at = 35, crc_at = 15;
   int prog_cnt = 0, rel_cnt = 0, edges = 0, hs_edges = 0, nb = 0, n_acc = 0;
   bit have_hs = 0, rel_init_low = 0;
   logic [7:0] sh = '0;
   logic prev_cclk = 1'b1, prev_din = 1'b1, prev_prog = 1'b1;
   int r5_bad = 0, gap = 1000, min_gap = 1000;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cfg_prog_n_o && !prev_prog) rel_init_low = !init_n_m;
         if (!cfg_prog_n_o) begin
            rel_cnt = 0; edges = 0; done_m = 1'b0; crc_fired = 0; nb = 0; have_hs = 0;
            if (allow_init_low) begin
               if (prog_cnt >= 4) init_n_m = 1'b0; else prog_cnt++;
            end
         end else begin
            prog_cnt = 0;
            if (!init_n_m && allow_init_high && !crc_fired) begin
               if (rel_cnt >= 4) init_n_m = 1'b1; else rel_cnt++;
            end
         end
         if (cfg_cclk_o && !prev_cclk) begin
            edges++; hs_edges++;
            sh = {sh[6:0], cfg_din_o};
            nb++;
            if (nb == 8) begin
               nb = 0;
               if (exp_q.size() > 0) begin
                  automatic logic [7:0] e = exp_q.pop_front();
                  chk(sh == e, "R4 byte order msb first", int'(sh), int'(e));
               end
            end
         end
         if (crc_mode && !crc_fired && edges == crc_at) begin
            init_n_m = 1'b0; crc_fired = 1;
         end
         if (allow_done && edges >= done_at) done_m = 1'b1;
         if (s_valid_i && s_ready_o) begin
            if (have_hs) chk(hs_edges == 8, "R7 edges between bytes", hs_edges, 8);
            have_hs = 1; hs_edges = 0; n_acc++;
         end
         if (cfg_din_o != prev_din && (cfg_cclk_o || prev_cclk)) r5_bad++;
         if ({cfg_prog_n_o, cfg_cclk_o, cfg_din_o} != {prev_prog, prev_cclk, prev_din}) begin
            if (gap < min_gap) min_gap = gap;
            gap = 1;
         end else begin
            gap++;
         end
      end
      prev_cclk = cfg_cclk_o;
      prev_din  = cfg_din_o;
      prev_prog = cfg_prog_n_o;
   end

   // ---------------- driver tasks ----------------
   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic send(input logic [7:0] b, input logic last, input int limit, output bit ok);
      ok = 0;
      s_data_i = b; s_last_i = last; s_valid_i = 1'b1;
      for (int w = 0; w < limit; w++) begin
         @(negedge clk);
         if (s_ready_o) begin ok = 1; break; end
      end
      if (ok) exp_q.push_back(b);
      @(posedge clk); #1;
      s_valid_i = 1'b0; s_last_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int w = 0; w < 20000; w++) begin
         @(negedge clk);
         if (!busy_o) break;
      end
   endtask

   initial begin
      bit ok;
      int t0;
      logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'h80, 8'h01};
      repeat (6) @(negedge clk);
      chk(cfg_prog_n_o && cfg_cclk_o && cfg_din_o, "R11 reset pins idle", {cfg_prog_n_o, cfg_cclk_o, cfg_din_o}, 7);
      chk(!s_ready_o && !busy_o && !done_o && !fail_o && !crc_err_o, "R11 reset status clear",
          {s_ready_o, busy_o, done_o, fail_o, crc_err_o}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // readback refused
      readback_i = 1'b1;
      @(negedge clk); readback_i = 1'b0;
      chk(fail_o && !done_o && !crc_err_o, "R10 readback fails", {fail_o, done_o, crc_err_o}, 4);
      chk(cfg_prog_n_o && cfg_cclk_o && cfg_din_o && !busy_o, "R10 no pin activity",
          {cfg_prog_n_o, cfg_cclk_o, cfg_din_o, busy_o}, 14);

      // init never goes low
      allow_init_low = 0;
      t0 = cyc;
      pulse_start();
      repeat (8) @(negedge clk);
      chk(!fail_o && busy_o, "R11 start clears fail", {fail_o, busy_o}, 1);
      repeat (100) @(negedge clk);
      chk(!cfg_prog_n_o, "R1 program held low", cfg_prog_n_o, 0);
      wait_idle();
      chk(fail_o && !crc_err_o && cfg_prog_n_o, "R2 init low timeout", {fail_o, crc_err_o, cfg_prog_n_o}, 5);
      chk(cyc - t0 >= TMO, "R2 timeout length", cyc - t0, TMO);
      allow_init_low = 1;

      // init never returns high
      allow_init_high = 0;
      pulse_start();
      repeat (8) @(negedge clk);
      chk(!fail_o, "R11 start clears fail again", fail_o, 0);
      wait_idle();
      chk(fail_o && !crc_err_o && !done_o, "R3 init high timeout", {fail_o, crc_err_o, done_o}, 4);
      chk(rel_init_low, "R1 program released after init low", rel_init_low, 1);
      allow_init_high = 1;
      @(negedge clk); init_n_m = 1'b1;
      repeat (4) @(negedge clk);

      // normal load, with a stray start during the run
      n_acc = 0; allow_done = 1; done_at = 4 * 8 + 3;
      pulse_start();
      for (int i = 0; i < 4; i++) begin
         if (i == 2) pulse_start();
         send(pat[i], i == 3, 3000, ok);
         chk(ok, "R7 byte accepted", ok, 1);
      end
      wait_idle();
      chk(done_o && !fail_o && !crc_err_o, "R9 done after flush", {done_o, fail_o, crc_err_o}, 4);
      chk(cfg_din_o, "R9 din high after data", cfg_din_o, 1);
      chk(rel_init_low, "R1 released only after init low", rel_init_low, 1);
      chk(exp_q.size() == 0 && n_acc == 4, "R4 all bytes shifted", n_acc, 4);
      repeat (40) @(negedge clk);
      chk(done_o && !busy_o, "R11 done sticky and stray start ignored", {done_o, busy_o}, 2);

      // CRC error before third byte
      n_acc = 0; allow_done = 0; crc_mode = 1; crc_at = 15;
      pulse_start();
      for (int i = 0; i < 3; i++) begin
         send(pat[i], 1'b0, (i == 2) ? 200 : 3000, ok);
         chk(ok == (i < 2), "R8 acceptance around crc", ok, i < 2);
         if (!ok) break;
      end
      wait_idle();
      chk(crc_err_o && fail_o && !done_o, "R8 crc reported", {crc_err_o, fail_o, done_o}, 6);
      chk(n_acc == 2 && exp_q.size() == 0, "R8 no byte after crc", n_acc, 2);
      crc_mode = 0;

      // done never rises
      pulse_start();
      send(8'h5A, 1'b1, 3000, ok);
      chk(ok, "R9 single byte accepted", ok, 1);
      wait_idle();
      chk(fail_o && !done_o && !crc_err_o, "R9 done timeout", {fail_o, done_o, crc_err_o}, 4);

      chk(r5_bad == 0, "R5 din moved under high clock", r5_bad, 0);
      chk(min_gap >= DIV, "R6 pin change spacing", min_gap, DIV);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule